// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block evaluates one of sixteen fixed operations on two 8-bit operands, selected by a 4-bit operation code. Both the result and a write-back request for a destination register are produced combinationally in the same cycle. Beside them it computes four status bits: zero, negative, carry and signed overflow. These are captured into a small flag register on the next rising clock edge, but only when the caller raises a flag-update enable.

The operation set has five groups:

- **Adder-based:** add, subtract, compare, increment, decrement and two's-complement negate.
- **Bitwise:** and, or, xor and invert.
- **Shifts:** one-place shifts left and right.
- **Pass-through:** a straight copy of the first operand.
- **Constants and idle:** all-zeros, all-ones and a do-nothing code.

Compare is a subtraction that only feeds the flags. The do-nothing code neither writes back nor disturbs the flags.

The block has no states of its own. The only stored state is the flag register. Its only transitions are "capture", when the enable is high and the operation code is not the idle code, and "hold" in every other cycle. Reset clears it.

Top module: `alu8_core`

## Requirements
- R1: The adder-based codes are 0x0 add (a+b), 0x1 subtract (a-b), 0x8 increment (a+1), 0x9 decrement (a-1) and 0xB negate (0-a). Each drives `result` with the 8-bit wrapped value.
- R2: The bitwise and copy codes use only their named operands. They are 0x2 a AND b, 0x3 a OR b, 0x4 a XOR b, 0x5 NOT a, and 0xC copy of a.
- R3: Code 0x6 shifts a left by one place and code 0x7 shifts a right by one place. A zero enters the vacated bit. The carry flag takes the bit shifted out: bit 7 for left, bit 0 for right.
- R4: Code 0xA (compare) updates the flags as for subtract and keeps `wr_en` low.
- R5: Code 0xD gives 0x00 and code 0xE gives 0xFF.
- R6: Code 0xF (idle) drives `wr_en` low and `result` to 0x00, and leaves `flags` unchanged even when `flag_en` is high.
- R7: `flags` is ordered {N,Z,C,V} from bit 3 down to bit 0. When captured, Z is 1 exactly when the 8-bit result is zero, and N equals result bit 7.
- R8: For the adder-based codes, C is the carry out of bit 7. Subtract, compare, decrement and negate compute a + NOT(y) + 1 style sums, so C=1 means no borrow. Decrement of 0x00 gives C=0, and negate gives C=1 only for 0x00. The bitwise, copy and constant codes give C=0.
- R9: V is 1 when the two addends share a sign and the sum's sign differs from it. V is always 0 for the bitwise, shift, copy and constant codes.
- R10: The flag register is cleared by reset. It captures only on a rising edge with `flag_en`=1 and holds otherwise.
- R11: `wr_en` is 1 for every code except compare (0xA) and idle (0xF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| opcode | input | 4 | Operation select |
| flag_en | input | 1 | Capture the computed flags at the next edge |
| result | output | 8 | Combinational result |
| wr_en | output | 1 | Destination write request |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
The hardest conditions to reach are those where carry and overflow part ways. These include a negate of 0x80 (overflow with no carry), a decrement of 0x00 (borrow), and a subtract that crosses the signed boundary. The stimulus targets these operand pairs directly before a random sweep.

Flag retention is also hard to observe. It is checked by first setting a recognisable flag pattern and then issuing the idle code, or any code with the enable low. The stored bits are read back at the port on the next edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_AND  = 4'h2,
        OP_OR   = 4'h3,
        OP_XOR  = 4'h4,
        OP_NOT  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_INC  = 4'h8,
        OP_DEC  = 4'h9,
        OP_CMP  = 4'hA,
        OP_NEG  = 4'hB,
        OP_PASS = 4'hC,
        OP_ZERO = 4'hD,
        OP_ONES = 4'hE,
        OP_IDLE = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        sum  = wide[MSB:0];
        co   = wide[W];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r,
    output logic         c
);
    localparam int MSB = W - 1;

    always_comb begin
        r = '0;
        c = 1'b0;
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_NOT:  r = ~a;
            OP_SHL:  begin r = {a[MSB-1:0], 1'b0}; c = a[MSB]; end
            OP_SHR:  begin r = {1'b0, a[MSB:1]};   c = a[0];   end
            OP_PASS: r = a;
            OP_ONES: r = '1;
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  flag_t d,
    output flag_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   opcode,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic [3:0]   flags
);
    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] add_x, add_y, add_s, bit_r;
    logic         add_ci, add_co, add_v, bit_c, use_add, upd;
    flag_t        f_next, f_q;

    assign op = alu_op_e'(opcode);

    always_comb begin
        add_x   = op_a;
        add_y   = op_b;
        add_ci  = 1'b0;
        use_add = 1'b1;
        unique case (op)
            OP_ADD:         ;
            OP_SUB, OP_CMP: begin add_y = ~op_b; add_ci = 1'b1; end
            OP_INC:         begin add_y = '0;    add_ci = 1'b1; end
            OP_DEC:         add_y = '1;
            OP_NEG:         begin add_x = '0; add_y = ~op_a; add_ci = 1'b1; end
            default:        use_add = 1'b0;
        endcase
    end

    alu8_adder #(.W(W)) u_add (
        .x(add_x), .y(add_y), .ci(add_ci),
        .sum(add_s), .co(add_co), .ovf(add_v)
    );

    alu8_bitops #(.W(W)) u_bit (
        .op(op), .a(op_a), .b(op_b), .r(bit_r), .c(bit_c)
    );

    always_comb begin
        result   = use_add ? add_s : bit_r;
        f_next.n = result[MSB];
        f_next.z = (result == '0);
        f_next.c = use_add ? add_co : bit_c;
        f_next.v = use_add ? add_v : 1'b0;
        wr_en    = (op != OP_IDLE) && (op != OP_CMP);
        upd      = flag_en && (op != OP_IDLE);
    end

    alu8_flagreg u_flags (
        .clk(clk), .rst_n(rst_n), .load(upd), .d(f_next), .q(f_q)
    );

    assign flags = f_q;

    p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 4'hF) |=> $stable(flags));

    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && opcode != 4'hF) |=> (flags[2] == ($past(result) == '0)));

    p_no_ovf_logic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && (opcode inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hC, 4'hD, 4'hE}))
        |=> !flags[0]);

    p_shl_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && opcode == 4'h6) |=> (flags[1] == $past(op_a[MSB])));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0;
    logic [3:0] opcode = 4'hF;
    logic       flag_en = 1'b0;
    logic [7:0] result;
    logic       wr_en;
    logic [3:0] flags;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] q_res[$];
    logic       q_wr[$];
    logic [3:0] q_flg[$];
    string      q_tag[$];
    logic [3:0] mflags = 4'h0;

    always #5 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .flag_en(flag_en), .result(result), .wr_en(wr_en), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Independent reference model following the requirement text
    task automatic model(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         output logic [7:0] r, output logic c, output logic v,
                         output logic w);
        logic [8:0] s;
        r = 8'h00; c = 1'b0; v = 1'b0; w = 1'b1;
        case (o)
            4'h0: begin s = a + b; r = s[7:0]; c = s[8];
                        v = (a[7] == b[7]) && (r[7] != a[7]); end
            4'h1, 4'hA: begin r = a - b; c = (a >= b);
                        v = (a[7] != b[7]) && (r[7] != a[7]); w = (o == 4'h1); end
            4'h2: r = a & b;
            4'h3: r = a | b;
            4'h4: r = a ^ b;
            4'h5: r = ~a;
            4'h6: begin r = a << 1; c = a[7]; end
            4'h7: begin r = a >> 1; c = a[0]; end
            4'h8: begin r = a + 8'd1; c = (a == 8'hFF); v = (a == 8'h7F); end
            4'h9: begin r = a - 8'd1; c = (a != 8'h00); v = (a == 8'h80); end
            4'hB: begin r = 8'h00 - a; c = (a == 8'h00); v = (a == 8'h80); end
            4'hC: r = a;
            4'hD: r = 8'h00;
            4'hE: r = 8'hFF;
            default: w = 1'b0;
        endcase
    endtask

    task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic en, input string tag);
        logic [7:0] r;
        logic c, v, w;
        @(negedge clk);
        opcode = o; op_a = a; op_b = b; flag_en = en;
        model(o, a, b, r, c, v, w);
        if (en && o != 4'hF) mflags = {r[7], (r == 8'h00), c, v};
        q_res.push_back(r);
        q_wr.push_back(w);
        q_flg.push_back(mflags);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare once the edge that consumes the item has passed
    always @(posedge clk) begin
        #2;
        if (q_res.size() > 0) begin
            logic [7:0] er;
            logic       ew;
            logic [3:0] ef;
            string      t;
            er = q_res.pop_front();
            ew = q_wr.pop_front();
            ef = q_flg.pop_front();
            t  = q_tag.pop_front();
            chk(result === er, t, "result", result, er);
            chk(wr_en === ew, {t, " R11"}, "wr_en", wr_en, ew);
            chk(flags === ef, t, "flags", flags, ef);
        end
    end

    initial begin
        #(20000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(flags === 4'h0, "R10", "reset flags", flags, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flags === 4'h0, "R10", "after reset", flags, 0);

        drive(4'h0, 8'h7F, 8'h01, 1, "R1 R9");
        drive(4'h0, 8'hFF, 8'h01, 1, "R1 R7 R8");
        drive(4'h0, 8'h80, 8'h80, 1, "R1 R8 R9");
        drive(4'h1, 8'h05, 8'h03, 1, "R1 R8");
        drive(4'h1, 8'h03, 8'h05, 1, "R1 R7 R8");
        drive(4'h1, 8'h80, 8'h01, 1, "R1 R9");
        drive(4'hA, 8'h42, 8'h42, 1, "R4");
        drive(4'hA, 8'h10, 8'h20, 1, "R4");
        drive(4'h2, 8'hF0, 8'h3C, 1, "R2");
        drive(4'h3, 8'hF0, 8'h0F, 1, "R2");
        drive(4'h4, 8'hAA, 8'hAA, 1, "R2 R7");
        drive(4'h5, 8'h0F, 8'hFF, 1, "R2");
        drive(4'hC, 8'h99, 8'h11, 1, "R2");
        drive(4'h6, 8'h81, 8'h00, 1, "R3");
        drive(4'h7, 8'h81, 8'h00, 1, "R3");
        drive(4'h7, 8'h80, 8'hFF, 1, "R3");
        drive(4'h8, 8'hFF, 8'h00, 1, "R1 R8");
        drive(4'h8, 8'h7F, 8'h00, 1, "R1 R9");
        drive(4'h9, 8'h00, 8'h00, 1, "R1 R8");
        drive(4'h9, 8'h80, 8'h00, 1, "R1 R9");
        drive(4'hB, 8'h00, 8'h00, 1, "R1 R8");
        drive(4'hB, 8'h80, 8'h00, 1, "R1 R9");
        drive(4'hB, 8'h01, 8'h00, 1, "R1 R8");
        drive(4'hD, 8'h55, 8'h55, 1, "R5 R7");
        drive(4'hE, 8'h00, 8'h00, 1, "R5");
        // Set a distinctive pattern, then idle with enable high
        drive(4'h0, 8'h80, 8'h80, 1, "R6");
        drive(4'hF, 8'h12, 8'h34, 1, "R6");
        drive(4'hF, 8'h00, 8'h00, 1, "R6");
        // Enable low: flags hold while result is still produced
        drive(4'h1, 8'h01, 8'h02, 0, "R10");
        drive(4'hD, 8'h00, 8'h00, 0, "R10");
        drive(4'hE, 8'h00, 8'h00, 1, "R10");

        for (int i = 0; i < 300; i++) begin
            drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                  1'($urandom), "R1 R2 R3 R7 R8 R9 R11");
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule